// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave with Relocatable Decode

This block is the slave end of an 8051-style multiplexed bus. The high address byte has its own pins. The low address byte shares eight lines with data, and an active-high latch-enable strobe qualifies it. On the falling edge of that strobe the block keeps the full 16-bit address. A later access then reaches either a byte array or a small register file that sits behind the bus. Writes take their data at the rising edge of the write strobe. Reads are served on either of two active-low strobes, one for program fetch and one for data read. This lets the same contents appear in both program space and data space. The shared pad is split into an input, an output and an output enable.

All strobes are asynchronous. Each one passes through a two-flop synchroniser into the system clock before it is used. A relocation register sets where the block sits in the 64 KB space, and it is reachable through the bus itself. The array window is `2**MEM_AW` bytes and is aligned to its own size. The register page is the 256-byte page that comes straight after the array window. In that page, offsets 0 to `GP_N-1` hold the general purpose registers and offset `GP_N` holds the relocation register.

Top module: `mbus_slave`

## Requirements
- R1: The address used by an access is `{a_hi, ad_in}` as sampled when the synchronised latch strobe `ale` falls. Later changes on `a_hi` or `ad_in` do not alter it.
- R2: A write takes effect when `wr_n` rises while `ce_n` is low. It stores `ad_in` at the latched address.
- R3: With `ce_n` low, a low `rd_n` returns the byte stored at the latched address on `ad_out`.
- R4: A low `psen_n` with `ce_n` low returns the same byte as `rd_n` does.
- R5: `ad_oe` rises at the second rising clock edge after a qualified read strobe falls. It drops at the second rising clock edge after that strobe rises.
- R6: The array window is hit when address bits [15:MEM_AW] equal relocation register bits [7:MEM_AW-8]. An address outside both windows leaves `ad_oe` low and `ad_out` at zero.
- R7: The register page is the page numbered `{tag+1, (MEM_AW-8) zero bits}`, where tag is the array window tag. Offsets below GP_N in that page select a general purpose register. Offset GP_N selects the relocation register. All other offsets miss.
- R8: Writing the relocation register moves both windows, and the tag increment wraps modulo 256 pages. Relocation register bits below MEM_AW-8 are stored but play no part in decoding.
- R9: After reset, the relocation register and every general purpose register read as zero.
- R10: While `ce_n` is high, strobes neither write nor drive the bus.
- R11: A write to an address that misses both windows changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, active high, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| psen_n | input | 1 | Program fetch strobe, active low |
| a_hi | input | 8 | High address byte |
| ad_in | input | 8 | Pad input: low address byte or write data |
| ad_out | output | 8 | Pad output: read data |
| ad_oe | output | 1 | Pad output enable |

## Verification
The bench builds the block with MEM_AW=9 and GP_N=16. This makes the array window two pages wide, so the tag is seven bits and one relocation register bit goes unused by decoding. With this setting, a write that aliases an array offset from outside the window can be tested, as can the register page directly above the array. Moving the base to the top of the space makes the register page wrap round to page zero, and the ignored low base bit can be shown to leave decoding unchanged.

// File: rtl/mbus_slave.sv
module mbus_slave #(
  parameter int MEM_AW = 10,
  parameter int GP_N   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       ce_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       psen_n,
  input  logic [7:0] a_hi,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe
);
  localparam int PG   = MEM_AW - 8;
  localparam int TAGW = 8 - PG;
  localparam int GPW  = $clog2(GP_N);

  logic [1:0] ale_m, ce_m, wr_m, rd_m, ps_m;
  logic       ale_q, wr_q;
  logic       ale_s, ce_s, wr_s, rd_s, ps_s;
  logic       ale_fall, wr_rise;

  logic [15:0] a_lat;
  logic [7:0]  map_base;
  logic [7:0]  gp [GP_N];
  logic [7:0]  mem [2**MEM_AW];

  logic [TAGW-1:0] mem_tag;
  logic [7:0]      reg_page;
  logic            mem_hit, in_page, gp_hit, base_hit, reg_hit;
  logic [7:0]      rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_m <= 2'b00;
      ce_m  <= 2'b11;
      wr_m  <= 2'b11;
      rd_m  <= 2'b11;
      ps_m  <= 2'b11;
      ale_q <= 1'b0;
      wr_q  <= 1'b1;
    end else begin
      ale_m <= {ale_m[0], ale};
      ce_m  <= {ce_m[0], ce_n};
      wr_m  <= {wr_m[0], wr_n};
      rd_m  <= {rd_m[0], rd_n};
      ps_m  <= {ps_m[0], psen_n};
      ale_q <= ale_m[1];
      wr_q  <= wr_m[1];
    end
  end

  assign ale_s = ale_m[1];
  assign ce_s  = ce_m[1];
  assign wr_s  = wr_m[1];
  assign rd_s  = rd_m[1];
  assign ps_s  = ps_m[1];

  assign ale_fall = ale_q & ~ale_s;
  assign wr_rise  = wr_s & ~wr_q & ~ce_s;

  assign mem_tag  = map_base[7:PG];
  assign mem_hit  = a_lat[15:MEM_AW] == mem_tag;
  assign reg_page = {mem_tag + TAGW'(1), {PG{1'b0}}};
  assign in_page  = a_lat[15:8] == reg_page;
  assign gp_hit   = in_page && (a_lat[7:0] < 8'(GP_N));
  assign base_hit = in_page && (a_lat[7:0] == 8'(GP_N));
  assign reg_hit  = gp_hit | base_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lat    <= '0;
      map_base <= '0;
      for (int i = 0; i < GP_N; i++) gp[i] <= '0;
    end else begin
      if (ale_fall) a_lat <= {a_hi, ad_in};
      if (wr_rise && gp_hit) gp[a_lat[GPW-1:0]] <= ad_in;
      if (wr_rise && base_hit) map_base <= ad_in;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_rise && mem_hit) mem[a_lat[MEM_AW-1:0]] <= ad_in;
  end

  always_comb begin
    rd_data = '0;
    if (mem_hit)       rd_data = mem[a_lat[MEM_AW-1:0]];
    else if (gp_hit)   rd_data = gp[a_lat[GPW-1:0]];
    else if (base_hit) rd_data = map_base;
  end

  assign ad_oe  = ~ce_s & (~rd_s | ~ps_s) & (mem_hit | reg_hit);
  assign ad_out = ad_oe ? rd_data : 8'h00;
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk #(
  parameter int MEM_AW = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ad_oe,
  input logic        ce_s,
  input logic        rd_s,
  input logic        ps_s,
  input logic        ale_fall,
  input logic        wr_rise,
  input logic [15:0] a_lat,
  input logic [7:0]  map_base
);
  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(a_lat));
  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(map_base));
  // R10
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> $stable(map_base));
  // R10
  ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |-> !ad_oe);
  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && ps_s) |-> !ad_oe);
  // R1
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> !ale_fall);
endmodule

bind mbus_slave mbus_slave_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .ce_s(ce_s), .rd_s(rd_s),
  .ps_s(ps_s), .ale_fall(ale_fall), .wr_rise(wr_rise), .a_lat(a_lat),
  .map_base(map_base)
);

// File: tb/sim_mbus_slave.sv
module sim_mbus_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, psen_n = 1'b1;
  logic [7:0] a_hi = 8'h00, ad_in = 8'h00;
  logic [7:0] ad_out;
  logic ad_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  mbus_slave #(.MEM_AW(9), .GP_N(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ce_n(ce_n), .wr_n(wr_n),
    .rd_n(rd_n), .psen_n(psen_n), .a_hi(a_hi), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [15:0] addr);
    ale = 1'b1; a_hi = addr[15:8]; ad_in = addr[7:0];
    wait_neg(3);
    ale = 1'b0;
    wait_neg(4);
    a_hi = ~addr[15:8]; ad_in = ~addr[7:0];
  endtask

  task automatic bus_write(input logic [15:0] addr, input logic [7:0] data, input bit sel);
    addr_phase(addr);
    ad_in = data; ce_n = ~sel; wr_n = 1'b0;
    wait_neg(4);
    wr_n = 1'b1;
    wait_neg(4);
    ce_n = 1'b1; ad_in = 8'h5A;
    wait_neg(2);
  endtask

  task automatic bus_read(input logic [15:0] addr, input bit use_psen, input bit sel,
                          output logic [8:0] res);
    addr_phase(addr);
    ce_n = ~sel;
    if (use_psen) psen_n = 1'b0; else rd_n = 1'b0;
    wait_neg(4);
    res = {ad_oe, ad_out};
    rd_n = 1'b1; psen_n = 1'b1;
    wait_neg(4);
    ce_n = 1'b1;
    wait_neg(2);
  endtask

  task automatic t_reset;
    logic [8:0] r;
    bus_read(16'h0205, 0, 1, r); check("R9 gp reset", r, 9'h100);
    bus_read(16'h0210, 0, 1, r); check("R9 base reset", r, 9'h100);
  endtask

  task automatic t_array;
    logic [8:0] r;
    bus_write(16'h0034, 8'hA5, 1);
    bus_read(16'h0034, 0, 1, r); check("R2 R3 rd read", r, 9'h1A5);
    bus_read(16'h0034, 1, 1, r); check("R4 psen read", r, 9'h1A5);
    bus_write(16'h01FF, 8'h3C, 1);
    bus_read(16'h01FF, 0, 1, r); check("R6 window top", r, 9'h13C);
    bus_read(16'h0034, 1, 1, r); check("R1 latched address kept", r, 9'h1A5);
  endtask

  task automatic t_regs;
    logic [8:0] r;
    bus_write(16'h020F, 8'h9E, 1);
    bus_read(16'h020F, 0, 1, r); check("R7 last gp reg", r, 9'h19E);
    bus_read(16'h0211, 0, 1, r); check("R7 page miss", r, 9'h000);
  endtask

  task automatic t_miss;
    logic [8:0] r;
    bus_read(16'h4000, 0, 1, r); check("R6 outside miss", r, 9'h000);
    bus_write(16'h4034, 8'h11, 1);
    bus_read(16'h0034, 0, 1, r); check("R11 alias write ignored", r, 9'h1A5);
  endtask

  task automatic t_ce;
    logic [8:0] r;
    bus_write(16'h0034, 8'h22, 0);
    bus_read(16'h0034, 0, 1, r); check("R10 write without ce", r, 9'h1A5);
    bus_read(16'h0034, 0, 0, r); check("R10 read without ce", r, 9'h000);
  endtask

  task automatic t_oe_timing;
    addr_phase(16'h0034);
    ce_n = 1'b0;
    wait_neg(3);
    rd_n = 1'b0;
    wait_neg(1); check("R5 oe not yet", {ad_oe, 8'h00}, 9'h000);
    wait_neg(1); check("R5 oe on", {ad_oe, ad_out}, 9'h1A5);
    rd_n = 1'b1;
    wait_neg(1); check("R5 oe held", {ad_oe, 8'h00}, 9'h100);
    wait_neg(1); check("R5 oe off", {ad_oe, ad_out}, 9'h000);
    ce_n = 1'b1;
    wait_neg(2);
  endtask

  task automatic t_relocate;
    logic [8:0] r;
    bus_write(16'h0210, 8'h40, 1);
    bus_read(16'h4034, 0, 1, r); check("R8 moved array", r, 9'h1A5);
    bus_read(16'h0034, 0, 1, r); check("R8 old window gone", r, 9'h000);
    bus_read(16'h420F, 1, 1, r); check("R8 moved regs", r, 9'h19E);
    bus_write(16'h4210, 8'h41, 1);
    bus_read(16'h4210, 0, 1, r); check("R8 base readback", r, 9'h141);
    bus_read(16'h41FF, 0, 1, r); check("R8 low base bit ignored", r, 9'h13C);
    bus_write(16'h4210, 8'hFE, 1);
    bus_read(16'hFE34, 0, 1, r); check("R8 top window", r, 9'h1A5);
    bus_read(16'h000F, 0, 1, r); check("R8 reg page wraps", r, 9'h19E);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(3);
    t_reset();
    t_array();
    t_regs();
    t_miss();
    t_ce();
    t_oe_timing();
    t_relocate();
    finish_run();
  end
endmodule